// File: doc/BRIEF.md
# Capability Memory with Hidden Validity Bits

This block is a small on-chip memory that holds 128-bit capability values in aligned 16-byte slots. Beside every slot it keeps one validity bit in a separate register array, outside the data payload. The bit records whether the slot currently holds a genuine capability. Ordinary integer writes can change the data, but they always knock the bit down. The bit can only go up when an already valid capability is stored through the capability-aware path, and only if the authorising capability grants permission to store capabilities.

A single request port takes integer stores (any subset of the 16 bytes, picked by byte enables), capability stores and capability loads. A capability load returns the data and the validity bit one cycle later. The bit reads as zero unless the authorising capability grants permission to load capabilities. Capability operations at an address that is not 16-byte aligned are refused with an error response and change nothing.

A second, privileged port reads and rewrites the validity bits of a whole page of slots at once. Swap code uses it to save the bits when a page is evicted and to put them back when the page returns.

Top module: `cap_tag_mem`

## Requirements
- R1: After reset every validity bit is 0, and `rsp_valid` and `tagio_rvalid` are 0.
- R2: An integer store (`req_op`=0) writes byte k of `req_wdata` (bits 8k+7:8k) into byte k of slot `req_addr[ADDR_W-1:4]` for every set bit k of `req_be`. The low four address bits are ignored. If any enable bit is set, the slot's validity bit is cleared, even when only one byte is written.
- R3: An integer store with `req_be` all zero changes neither the data nor the validity bit of any slot.
- R4: An aligned capability store (`req_op`=1, `req_addr[3:0]`=0) writes all 128 bits. It sets the slot's validity bit to `req_src_tag` AND `req_perm[1]`, where bit 1 is the store-capability permission.
- R5: A capability store or load whose `req_addr[3:0]` is nonzero changes no data and no validity bit. One cycle later it gives `rsp_valid`=1, `rsp_err`=1, `rsp_data`=0 and `rsp_tag`=0.
- R6: An aligned capability load (`req_op`=2) gives, one cycle later, `rsp_valid`=1, `rsp_err`=0, the slot's data, and `rsp_tag` = the stored bit AND `req_perm[0]`, where bit 0 is the load-capability permission.
- R7: No validity bit becomes 1 except through an R4 store with both source bit and store permission set, or through an R9 restore.
- R8: A pulse on `tagio_rd` with page p gives, one cycle later, `tagio_rvalid`=1 and `tagio_rbits` bit j = validity bit of slot p*PAGE_SLOTS+j. The values are those from before any update in the same cycle.
- R9: A pulse on `tagio_wr` with page p loads the page's validity bits from `tagio_wbits` (bit j to slot p*PAGE_SLOTS+j) and leaves the data untouched.
- R10: When a request-port store and a restore hit the same slot in the same cycle, the request-port result decides that slot's validity bit.
- R11: A request with `req_op`=3 is ignored. It gives no response and changes no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 integer store, 1 capability store, 2 capability load, 3 no operation |
| req_addr | input | ADDR_W | Byte address; upper bits pick the slot |
| req_wdata | input | 128 | Store data |
| req_be | input | 16 | Byte enables for integer stores |
| req_src_tag | input | 1 | Validity bit of the source capability register |
| req_perm | input | 2 | Authorising permissions: bit 0 load-capability, bit 1 store-capability |
| rsp_valid | output | 1 | Response for a load or a refused capability operation |
| rsp_err | output | 1 | Alignment error |
| rsp_data | output | 128 | Loaded data (zero on error) |
| rsp_tag | output | 1 | Returned validity bit |
| tagio_rd | input | 1 | Read a page of validity bits |
| tagio_wr | input | 1 | Restore a page of validity bits |
| tagio_page | input | PAGE_W | Page index for the side port |
| tagio_wbits | input | PAGE_SLOTS | Bits to restore |
| tagio_rvalid | output | 1 | Side read result valid |
| tagio_rbits | output | PAGE_SLOTS | Side read result |

## Verification
The hardest case to reach is the same-cycle clash between a page restore and a request-port store to a slot inside that page. In that cycle the validity bit has two writers, and the side read of that page must still report the old bits. The bench drives the side port and the request port together on purpose. It does this in directed cycles and also in a long random run where the restore page is drawn so that it often covers the stored slot. A behavioural model applies the restore first and the store second, then checks every response and every page readback against it.

// File: rtl/cm_pkg.sv
package cm_pkg;
  localparam int CAP_BITS  = 128;
  localparam int CAP_BYTES = CAP_BITS / 8;
  localparam int OFF_W     = $clog2(CAP_BYTES);
  localparam int PERM_LDCAP = 0;
  localparam int PERM_STCAP = 1;

  typedef enum logic [1:0] {
    OP_INT_ST = 2'd0,
    OP_CAP_ST = 2'd1,
    OP_CAP_LD = 2'd2,
    OP_NOP    = 2'd3
  } cm_op_e;

  function automatic logic cap_aligned(input logic [OFF_W-1:0] off);
    return off == '0;
  endfunction

  function automatic logic stored_tag(input logic src, input logic [1:0] perm);
    return src & perm[PERM_STCAP];
  endfunction

  function automatic logic loaded_tag(input logic held, input logic [1:0] perm);
    return held & perm[PERM_LDCAP];
  endfunction
endpackage

// File: rtl/cm_req_decode.sv
module cm_req_decode
  import cm_pkg::*;
#(
  parameter int SLOT_W = 6,
  localparam int ADDR_W = SLOT_W + OFF_W
) (
  input  logic                 req_valid,
  input  logic [1:0]           req_op,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [CAP_BYTES-1:0] req_be,
  input  logic                 req_src_tag,
  input  logic [1:0]           req_perm,
  output logic [SLOT_W-1:0]    slot,
  output logic                 data_we,
  output logic [CAP_BYTES-1:0] data_be,
  output logic                 tag_wr,
  output logic                 tag_val,
  output logic                 ld_en,
  output logic                 mis_err
);
  cm_op_e op;
  logic   aligned;

  always_comb begin
    op      = cm_op_e'(req_op);
    aligned = cap_aligned(req_addr[OFF_W-1:0]);
    slot    = req_addr[ADDR_W-1:OFF_W];
    data_we = 1'b0;
    data_be = '0;
    tag_wr  = 1'b0;
    tag_val = 1'b0;
    ld_en   = 1'b0;
    mis_err = 1'b0;
    if (req_valid) begin
      unique case (op)
        OP_INT_ST: begin
          data_we = |req_be;
          data_be = req_be;
          tag_wr  = |req_be;
        end
        OP_CAP_ST: begin
          if (aligned) begin
            data_we = 1'b1;
            data_be = '1;
            tag_wr  = 1'b1;
            tag_val = stored_tag(req_src_tag, req_perm);
          end else begin
            mis_err = 1'b1;
          end
        end
        OP_CAP_LD: begin
          if (aligned) ld_en = 1'b1;
          else         mis_err = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cm_data_bank.sv
module cm_data_bank
  import cm_pkg::*;
#(
  parameter int SLOTS = 64,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [CAP_BYTES-1:0] be,
  input  logic [SLOT_W-1:0]    slot,
  input  logic [CAP_BITS-1:0]  wdata,
  input  logic                 rd_en,
  output logic [CAP_BITS-1:0]  rdata
);
  logic [7:0] mem [SLOTS][CAP_BYTES];

  always_ff @(posedge clk) begin
    for (int b = 0; b < CAP_BYTES; b++) begin
      if (we && be[b]) mem[slot][b] <= wdata[8*b +: 8];
      if (rd_en) rdata[8*b +: 8] <= mem[slot][b];
    end
  end
endmodule

// File: rtl/cm_tag_bank.sv
module cm_tag_bank #(
  parameter int SLOTS = 64,
  parameter int PAGE_SLOTS = 8,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int PAGE_W = $clog2(SLOTS / PAGE_SLOTS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [SLOT_W-1:0]     wr_slot,
  input  logic                  wr_val,
  output logic                  slot_tag,
  input  logic [PAGE_W-1:0]     side_page,
  input  logic                  side_rd,
  input  logic                  side_wr,
  input  logic [PAGE_SLOTS-1:0] side_bits,
  output logic                  side_rvalid,
  output logic [PAGE_SLOTS-1:0] side_rbits
);
  logic [SLOTS-1:0] tags;

  assign slot_tag = tags[wr_slot];

  // request-port write is applied last so it wins over a same-cycle restore
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tags <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (wr_en && wr_slot == SLOT_W'(i))
          tags[i] <= wr_val;
        else if (side_wr && side_page == PAGE_W'(i / PAGE_SLOTS))
          tags[i] <= side_bits[i % PAGE_SLOTS];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      side_rvalid <= 1'b0;
      side_rbits  <= '0;
    end else begin
      side_rvalid <= side_rd;
      if (side_rd) side_rbits <= tags[side_page * PAGE_SLOTS +: PAGE_SLOTS];
    end
  end

  // R2: a clearing write leaves the slot's bit at zero
  a_r2_clear_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_val) |=> !tags[$past(wr_slot)]);

  generate
    for (genvar g = 0; g < SLOTS; g++) begin : g_forge
      // R7: a bit only rises from a valid store or a restore of a one
      a_r7_no_forge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tags[g]) |->
          $past((wr_en && wr_slot == SLOT_W'(g) && wr_val) ||
                (side_wr && side_page == PAGE_W'(g / PAGE_SLOTS) &&
                 side_bits[g % PAGE_SLOTS])));
    end
  endgenerate
endmodule

// File: rtl/cap_tag_mem.sv
module cap_tag_mem
  import cm_pkg::*;
#(
  parameter int SLOTS = 64,
  parameter int PAGE_SLOTS = 8,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int ADDR_W = SLOT_W + OFF_W,
  localparam int PAGE_W = $clog2(SLOTS / PAGE_SLOTS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [1:0]            req_op,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [127:0]          req_wdata,
  input  logic [15:0]           req_be,
  input  logic                  req_src_tag,
  input  logic [1:0]            req_perm,
  output logic                  rsp_valid,
  output logic                  rsp_err,
  output logic [127:0]          rsp_data,
  output logic                  rsp_tag,
  input  logic                  tagio_rd,
  input  logic                  tagio_wr,
  input  logic [PAGE_W-1:0]     tagio_page,
  input  logic [PAGE_SLOTS-1:0] tagio_wbits,
  output logic                  tagio_rvalid,
  output logic [PAGE_SLOTS-1:0] tagio_rbits
);
  logic [SLOT_W-1:0]    slot;
  logic                 data_we;
  logic [CAP_BYTES-1:0] data_be;
  logic                 tag_wr;
  logic                 tag_val;
  logic                 ld_en;
  logic                 mis_err;
  logic                 slot_tag;
  logic [CAP_BITS-1:0]  bank_rdata;

  cm_req_decode #(.SLOT_W(SLOT_W)) u_dec (
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_be(req_be), .req_src_tag(req_src_tag), .req_perm(req_perm),
    .slot(slot), .data_we(data_we), .data_be(data_be), .tag_wr(tag_wr),
    .tag_val(tag_val), .ld_en(ld_en), .mis_err(mis_err)
  );

  cm_data_bank #(.SLOTS(SLOTS)) u_data (
    .clk(clk), .we(data_we), .be(data_be), .slot(slot),
    .wdata(req_wdata), .rd_en(ld_en), .rdata(bank_rdata)
  );

  cm_tag_bank #(.SLOTS(SLOTS), .PAGE_SLOTS(PAGE_SLOTS)) u_tags (
    .clk(clk), .rst_n(rst_n), .wr_en(tag_wr), .wr_slot(slot),
    .wr_val(tag_val), .slot_tag(slot_tag), .side_page(tagio_page),
    .side_rd(tagio_rd), .side_wr(tagio_wr), .side_bits(tagio_wbits),
    .side_rvalid(tagio_rvalid), .side_rbits(tagio_rbits)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_tag   <= 1'b0;
    end else begin
      rsp_valid <= ld_en | mis_err;
      rsp_err   <= mis_err;
      rsp_tag   <= ld_en ? loaded_tag(slot_tag, req_perm) : 1'b0;
    end
  end

  assign rsp_data = rsp_err ? '0 : bank_rdata;

  // R5: misaligned capability access is refused next cycle
  a_r5_misalign_err: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_op == 2'd1 || req_op == 2'd2) && req_addr[OFF_W-1:0] != '0)
      |=> (rsp_valid && rsp_err && !rsp_tag && rsp_data == '0));

  // R6: without load-capability permission the returned bit is zero
  a_r6_load_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd2 && !req_perm[PERM_LDCAP]) |=> !rsp_tag);

  // R11: the spare opcode produces no response
  a_r11_nop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd3) |=> !rsp_valid);

  // R8: a side read answers on the next cycle
  a_r8_side_answer: assert property (@(posedge clk) disable iff (!rst_n)
    tagio_rd |=> tagio_rvalid);
endmodule

// File: tb/cap_tag_mem_test.sv
`timescale 1ns/1ps
module cap_tag_mem_test;
  localparam int SLOTS = 64;
  localparam int PS = 8;
  localparam int PAGES = SLOTS / PS;
  localparam int ADDR_W = $clog2(SLOTS) + 4;
  localparam int PAGE_W = $clog2(PAGES);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'd3;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [127:0] req_wdata = '0;
  logic [15:0] req_be = '0;
  logic req_src_tag = 1'b0;
  logic [1:0] req_perm = 2'b00;
  logic rsp_valid, rsp_err, rsp_tag;
  logic [127:0] rsp_data;
  logic tagio_rd = 1'b0, tagio_wr = 1'b0;
  logic [PAGE_W-1:0] tagio_page = '0;
  logic [PS-1:0] tagio_wbits = '0;
  logic tagio_rvalid;
  logic [PS-1:0] tagio_rbits;

  int n_checks = 0;
  int n_fail = 0;

  logic [127:0] md [SLOTS];
  logic mt [SLOTS];

  always #2.5 clk = ~clk;

  cap_tag_mem #(.SLOTS(SLOTS), .PAGE_SLOTS(PS)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_src_tag(req_src_tag), .req_perm(req_perm), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_data(rsp_data), .rsp_tag(rsp_tag),
    .tagio_rd(tagio_rd), .tagio_wr(tagio_wr), .tagio_page(tagio_page),
    .tagio_wbits(tagio_wbits), .tagio_rvalid(tagio_rvalid),
    .tagio_rbits(tagio_rbits)
  );

  task automatic check(input logic ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one clock: drive, predict from model, update model, compare after the edge
  task automatic cyc(input logic v, input logic [1:0] op, input int s,
                     input logic [3:0] off, input logic [127:0] d,
                     input logic [15:0] be, input logic st, input logic [1:0] pm,
                     input logic srd, input logic swr, input int pg,
                     input logic [PS-1:0] bits, input string req);
    logic e_v, e_err, e_tag, e_rv;
    logic [127:0] e_d;
    logic [PS-1:0] e_rb;
    req_valid = v; req_op = op; req_addr = {s[ADDR_W-5:0], off};
    req_wdata = d; req_be = be; req_src_tag = st; req_perm = pm;
    tagio_rd = srd; tagio_wr = swr; tagio_page = pg[PAGE_W-1:0]; tagio_wbits = bits;
    e_v = 1'b0; e_err = 1'b0; e_tag = 1'b0; e_d = '0;
    if (v && (op == 2'd1 || op == 2'd2) && off != 4'd0) begin
      e_v = 1'b1; e_err = 1'b1;
    end else if (v && op == 2'd2) begin
      e_v = 1'b1; e_d = md[s]; e_tag = mt[s] & pm[0];
    end
    e_rv = srd;
    for (int j = 0; j < PS; j++) e_rb[j] = mt[pg*PS + j];
    if (swr) for (int j = 0; j < PS; j++) mt[pg*PS + j] = bits[j];
    if (v && op == 2'd0 && be != '0) begin
      for (int b = 0; b < 16; b++) if (be[b]) md[s][8*b +: 8] = d[8*b +: 8];
      mt[s] = 1'b0;
    end
    if (v && op == 2'd1 && off == 4'd0) begin
      md[s] = d; mt[s] = st & pm[1];
    end
    @(posedge clk); #1;
    check(rsp_valid == e_v, req, "rsp_valid", 128'(rsp_valid), 128'(e_v));
    if (e_v) begin
      check(rsp_err == e_err, req, "rsp_err", 128'(rsp_err), 128'(e_err));
      check(rsp_data == e_d, req, "rsp_data", rsp_data, e_d);
      check(rsp_tag == e_tag, req, "rsp_tag", 128'(rsp_tag), 128'(e_tag));
    end
    check(tagio_rvalid == e_rv, req, "tagio_rvalid", 128'(tagio_rvalid), 128'(e_rv));
    if (e_rv) check(tagio_rbits == e_rb, req, "tagio_rbits", 128'(tagio_rbits), 128'(e_rb));
    req_valid = 1'b0; tagio_rd = 1'b0; tagio_wr = 1'b0;
  endtask

  task automatic int_st(input int s, input logic [3:0] off, input logic [127:0] d,
                        input logic [15:0] be, input string req);
    cyc(1, 2'd0, s, off, d, be, 1'b1, 2'b11, 0, 0, 0, '0, req);
  endtask
  task automatic cap_st(input int s, input logic [3:0] off, input logic [127:0] d,
                        input logic st, input logic [1:0] pm, input string req);
    cyc(1, 2'd1, s, off, d, '0, st, pm, 0, 0, 0, '0, req);
  endtask
  task automatic cap_ld(input int s, input logic [3:0] off, input logic [1:0] pm,
                        input string req);
    cyc(1, 2'd2, s, off, '0, '0, 1'b0, pm, 0, 0, 0, '0, req);
  endtask
  task automatic side_rd(input int pg, input string req);
    cyc(0, 2'd3, 0, 0, '0, '0, 0, 2'b00, 1, 0, pg, '0, req);
  endtask
  task automatic side_wr(input int pg, input logic [PS-1:0] bits, input string req);
    cyc(0, 2'd3, 0, 0, '0, '0, 0, 2'b00, 0, 1, pg, bits, req);
  endtask

  initial begin
    #(5.0 * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < SLOTS; i++) begin md[i] = '0; mt[i] = 1'b0; end
    repeat (3) @(posedge clk);
    #1;
    check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", 128'(rsp_valid), 128'(0));
    check(tagio_rvalid == 1'b0, "R1", "tagio_rvalid in reset", 128'(tagio_rvalid), 128'(0));
    rst_n = 1'b1;
    // R1: all pages read back zero
    for (int p = 0; p < PAGES; p++) side_rd(p, "R1");
    for (int i = 0; i < SLOTS; i++) cap_st(i, 0, '0, 1'b0, 2'b11, "R4");

    // R4 / R6: valid store with permission, load with and without permission
    cap_st(5, 0, 128'hA5A5_0000_1111_2222_3333_4444_5555_6666, 1, 2'b10, "R4");
    cap_ld(5, 0, 2'b01, "R6");
    cap_ld(5, 0, 2'b00, "R6");
    // R4: no store permission drops the bit
    cap_st(6, 0, 128'h1234, 1, 2'b01, "R4");
    cap_ld(6, 0, 2'b01, "R4");
    // R7: invalid source never yields a set bit
    cap_st(7, 0, 128'hFFFF, 0, 2'b11, "R7");
    cap_ld(7, 0, 2'b11, "R7");
    // R2: single byte store clears a valid bit, merges data
    cap_st(9, 0, {4{32'hCAFE_F00D}}, 1, 2'b11, "R2");
    int_st(9, 4'd7, 128'h0000_0000_0000_0000_0000_0000_0000_00EE, 16'h0001, "R2");
    cap_ld(9, 0, 2'b11, "R2");
    int_st(9, 4'd0, '1, 16'hFFFF, "R7");
    cap_ld(9, 0, 2'b11, "R7");
    // R3: zero enables touch nothing
    cap_st(10, 0, 128'h55, 1, 2'b11, "R3");
    int_st(10, 0, '1, 16'h0000, "R3");
    cap_ld(10, 0, 2'b11, "R3");
    // R5: misaligned store and load
    cap_st(10, 4'd8, '1, 1, 2'b11, "R5");
    cap_ld(10, 4'd4, 2'b11, "R5");
    cap_ld(10, 0, 2'b11, "R5");
    // R11: spare opcode
    cyc(1, 2'd3, 10, 0, '1, '1, 1, 2'b11, 0, 0, 0, '0, "R11");
    cap_ld(10, 0, 2'b11, "R11");
    // R8 / R9: save, clobber, restore page 1
    side_rd(1, "R8");
    side_wr(1, 8'hFF, "R9");
    side_rd(1, "R9");
    cap_ld(9, 0, 2'b11, "R9");
    side_wr(1, 8'b0000_0100, "R9");
    side_rd(1, "R8");
    // R10: restore and store clash on slot 13 (page 1)
    cyc(1, 2'd0, 13, 0, 128'h77, 16'h0002, 0, 2'b11, 1, 1, 1, 8'hFF, "R10");
    side_rd(1, "R10");
    cyc(1, 2'd1, 12, 0, 128'h99, '0, 1, 2'b11, 1, 1, 1, 8'h00, "R10");
    cap_ld(12, 0, 2'b01, "R10");
    // random mixed traffic against the model
    for (int k = 0; k < 3000; k++) begin
      int s, pg;
      logic [1:0] op;
      s = $urandom_range(0, SLOTS-1);
      pg = ($urandom_range(0, 1) == 1) ? s / PS : $urandom_range(0, PAGES-1);
      op = 2'($urandom_range(0, 3));
      cyc($urandom_range(0, 3) != 0, op, s,
          ($urandom_range(0, 3) == 0) ? 4'($urandom_range(1, 15)) : 4'd0,
          {$urandom, $urandom, $urandom, $urandom},
          ($urandom_range(0, 3) == 0) ? 16'h0 : 16'($urandom),
          1'($urandom), 2'($urandom),
          $urandom_range(0, 2) == 0, $urandom_range(0, 4) == 0, pg, 8'($urandom),
          op == 2'd0 ? "R2" : op == 2'd1 ? "R4" : op == 2'd2 ? "R6" : "R11");
    end
    for (int p = 0; p < PAGES; p++) side_rd(p, "R8");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule